// File: doc/BRIEF.md
# Pulse Template Correlator Channel

This block correlates a stream of signed 4-bit samples against a template made of rectangular pulses whose polarities follow a 31-chip Gold sequence. On each slow clock it takes a group of four consecutive samples and adds them. Adding four samples is the same as correlating them with one rectangular pulse. The chip in force then decides whether that term is added to or subtracted from a running total. The block keeps five running totals and rotates among them, one per cycle. As a result it tracks five neighbouring timing offsets at the same time with a single adder.

Two programmable 5-bit shift registers produce the code. The feedback taps and the start value of each register come in on ports. The chip changes every five cycles, so one bit spans 31 × 5 = 155 cycles. At the end of a bit the five totals appear together on the output with a one-cycle strobe, and the totals restart from zero. A code-restart input abandons the bit in progress and starts a fresh one.

Top module: `pulse_corr_channel`

## Requirements
- R1: While and after reset, with no bit yet complete, `corr_valid` is 0, `corr_out` is all zeros, and `chip_out` equals `seed_a[0] ^ seed_b[0]`.
- R2: Each cycle's term is the two's-complement sum of the four signed lanes of `smp_in`. Lane i occupies bits [4i+3:4i].
- R3: When the current chip is 0 the term is added to the selected total. When the chip is 1 the term is subtracted.
- R4: Cycle t of a bit (t = 0..154) updates total number t mod 5 only. That total is reported in slot k = t mod 5, at `corr_out[k*ACC_W +: ACC_W]`.
- R5: The chip used in cycle t is chip number t/5 (integer division). `chip_out` changes only after the fifth cycle of a chip, or after a restart.
- R6: Chip j is a[0] ^ b[0] of the two registers after j steps. Each register starts from its seed at the beginning of every bit. Each step maps r to {parity(r & poly), r[4:1]}.
- R7: One cycle after the 155th cycle of a bit, `corr_valid` is high for exactly one cycle. `corr_out` then holds the five totals until the next strobe, and the next bit accumulates from zero.
- R8: Each total saturates at the signed ACC_W-bit limits, from −2^(ACC_W−1) to 2^(ACC_W−1)−1, instead of wrapping.
- R9: A cycle with `code_rst` high discards the totals, reloads both seeds and restarts the cycle count. That cycle's samples are not accumulated, and the abandoned bit produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sample-group clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_rst | input | 1 | Restart the bit: reload seeds, clear totals |
| smp_in | input | LANES*SMP_W | Four signed samples, lane 0 in the low bits |
| poly_a | input | LFSR_W | Feedback taps of code register A |
| poly_b | input | LFSR_W | Feedback taps of code register B |
| seed_a | input | LFSR_W | Start value of code register A |
| seed_b | input | LFSR_W | Start value of code register B |
| corr_out | output | TAPS*ACC_W | Five signed totals of the last completed bit |
| corr_valid | output | 1 | One-cycle strobe when `corr_out` is updated |
| chip_out | output | 1 | Code chip applied in the current cycle |

## Verification
The bench builds the channel with ACC_W = 8 and leaves every other parameter at its default. With 11 bits, 31 terms of at most 32 in magnitude reach only 992, so the saturation limits could never be hit. With 8 bits, bits driven coherently with the code drive the totals into both rails. Between bits, the code taps and seeds are changed under a restart, so the generator runs through more than one sequence. A bit is also abandoned midway to show that it leaves no strobe and no residue.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic {CHIP_ADD = 1'b0, CHIP_SUB = 1'b1} chip_op_e;

  // clip an integer into the signed range of a w-bit word
  function automatic int sat_to_width(int v, int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // the +/-1 multiply: pick the term or its negation
  function automatic int signed_mac(int acc, int t, chip_op_e op);
    return (op == CHIP_SUB) ? acc - t : acc + t;
  endfunction

endpackage

// File: rtl/pcc_sum.sv
module pcc_sum #(
  parameter int LANES = 4,
  parameter int SMP_W = 4,
  parameter int TW    = SMP_W + $clog2(LANES)
) (
  input  logic [LANES*SMP_W-1:0] smp,
  output logic signed [TW-1:0]   term
);
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + int'($signed(smp[i*SMP_W +: SMP_W]));
    end
    term = TW'(acc);
  end
endmodule

// File: rtl/pcc_lfsr.sv
module pcc_lfsr #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [LW-1:0] poly,
  input  logic [LW-1:0] seed,
  output logic          lsb
);
  logic [LW-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n || load) st <= seed;
    else if (step)      st <= {^(st & poly), st[LW-1:1]};
  end

  assign lsb = st[0];
endmodule

// File: rtl/pcc_gold.sv
module pcc_gold #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [LW-1:0] poly_a,
  input  logic [LW-1:0] poly_b,
  input  logic [LW-1:0] seed_a,
  input  logic [LW-1:0] seed_b,
  output logic          chip
);
  logic bit_a;
  logic bit_b;

  pcc_lfsr #(.LW(LW)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .poly(poly_a), .seed(seed_a), .lsb(bit_a)
  );

  pcc_lfsr #(.LW(LW)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .poly(poly_b), .seed(seed_b), .lsb(bit_b)
  );

  assign chip = bit_a ^ bit_b;
endmodule

// File: rtl/pcc_ring.sv
module pcc_ring #(
  parameter int TAPS = 5,
  parameter int TW   = 6,
  parameter int AW   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic signed [TW-1:0] term,
  input  logic                 chip,
  output logic signed [AW-1:0] acc_old,
  output logic signed [AW-1:0] acc_new,
  output logic [TAPS*AW-1:0]   snap
);
  import pcc_pkg::*;

  logic signed [AW-1:0] stg [TAPS];

  // the last stage holds the total of the same offset, five cycles back
  assign acc_old = stg[TAPS-1];

  always_comb begin
    acc_new = AW'(sat_to_width(signed_mac(int'(acc_old), int'(term),
                                          chip_op_e'(chip)), AW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < TAPS; i++) stg[i] <= '0;
    end else begin
      stg[0] <= acc_new;
      for (int i = 1; i < TAPS; i++) stg[i] <= stg[i-1];
    end
  end

  // at the last cycle of a bit, slot k sits TAPS-2-k stages down the chain
  genvar k;
  generate
    for (k = 0; k < TAPS - 1; k++) begin : g_slot
      assign snap[k*AW +: AW] = stg[TAPS-2-k];
    end
  endgenerate
  assign snap[(TAPS-1)*AW +: AW] = acc_new;
endmodule

// File: rtl/pulse_corr_channel.sv
module pulse_corr_channel #(
  parameter int SMP_W    = 4,
  parameter int LANES    = 4,
  parameter int TAPS     = 5,
  parameter int CODE_LEN = 31,
  parameter int LFSR_W   = 5,
  parameter int ACC_W    = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     code_rst,
  input  logic [LANES*SMP_W-1:0]   smp_in,
  input  logic [LFSR_W-1:0]        poly_a,
  input  logic [LFSR_W-1:0]        poly_b,
  input  logic [LFSR_W-1:0]        seed_a,
  input  logic [LFSR_W-1:0]        seed_b,
  output logic [TAPS*ACC_W-1:0]    corr_out,
  output logic                     corr_valid,
  output logic                     chip_out
);
  localparam int TW = SMP_W + $clog2(LANES);
  localparam int PW = $clog2(TAPS);
  localparam int CW = $clog2(CODE_LEN);

  logic [PW-1:0]            phase;
  logic [CW-1:0]            chip_idx;
  logic                     last_phase;
  logic                     bit_end;
  logic                     seq_clear;
  logic                     code_step;
  logic signed [TW-1:0]     term;
  logic signed [ACC_W-1:0]  acc_old;
  logic signed [ACC_W-1:0]  acc_new;
  logic [TAPS*ACC_W-1:0]    snap;

  assign last_phase = (phase == PW'(TAPS - 1));
  assign bit_end    = last_phase && (chip_idx == CW'(CODE_LEN - 1));
  assign seq_clear  = code_rst || bit_end;
  assign code_step  = last_phase && !seq_clear;

  always_ff @(posedge clk) begin
    if (!rst_n || seq_clear) begin
      phase    <= '0;
      chip_idx <= '0;
    end else if (last_phase) begin
      phase    <= '0;
      chip_idx <= chip_idx + 1'b1;
    end else begin
      phase    <= phase + 1'b1;
    end
  end

  pcc_sum #(.LANES(LANES), .SMP_W(SMP_W), .TW(TW)) u_sum (
    .smp(smp_in), .term(term)
  );

  pcc_gold #(.LW(LFSR_W)) u_gold (
    .clk(clk), .rst_n(rst_n), .load(seq_clear), .step(code_step),
    .poly_a(poly_a), .poly_b(poly_b), .seed_a(seed_a), .seed_b(seed_b),
    .chip(chip_out)
  );

  // a restart cycle clears the ring, so its term never lands
  pcc_ring #(.TAPS(TAPS), .TW(TW), .AW(ACC_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .term(term),
    .chip(chip_out), .acc_old(acc_old), .acc_new(acc_new), .snap(snap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_out   <= '0;
      corr_valid <= 1'b0;
    end else begin
      corr_valid <= bit_end && !code_rst;
      if (bit_end && !code_rst) corr_out <= snap;
    end
  end
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
  parameter int AW   = 11,
  parameter int TAPS = 5,
  parameter int TW   = 6,
  parameter int PW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 code_rst,
  input logic                 corr_valid,
  input logic [TAPS*AW-1:0]   corr_out,
  input logic                 chip_out,
  input logic [PW-1:0]        phase,
  input logic signed [TW-1:0] term,
  input logic signed [AW-1:0] acc_old,
  input logic signed [AW-1:0] acc_new
);
  localparam logic signed [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> !corr_valid);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_valid |-> $stable(corr_out));

  p_rst_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_rst |=> !corr_valid);

  p_chip_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase) != TAPS - 1 && !code_rst) |=> $stable(chip_out));

  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < TAPS);

  p_sign_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_out && term > 0 && acc_old < MAXV) |-> acc_new > acc_old);

  p_sign_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_out && term > 0 && acc_old > MINV) |-> acc_new < acc_old);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_old == MAXV && !chip_out && term > 0) |-> acc_new == MAXV);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_old == MINV && chip_out && term > 0) |-> acc_new == MINV);
endmodule

bind pulse_corr_channel pcc_chk #(
  .AW(ACC_W), .TAPS(TAPS), .TW(TW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .code_rst(code_rst), .corr_valid(corr_valid),
  .corr_out(corr_out), .chip_out(chip_out), .phase(phase), .term(term),
  .acc_old(acc_old), .acc_new(acc_new)
);

// File: tb/tb_pulse_corr_channel.sv
`timescale 1ns/1ps
module tb_pulse_corr_channel;
  localparam int AW = 8;
  localparam int NT = 5;
  localparam int NC = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_rst = 1'b0;
  logic [15:0] smp_in = '0;
  logic [4:0] poly_a, poly_b, seed_a, seed_b;
  logic [NT*AW-1:0] corr_out;
  logic corr_valid;
  logic chip_out;

  int checks = 0;
  int errors = 0;
  int got_bits = 0;
  int sent_bits = 0;
  bit done = 0;
  bit chips [NC];
  int acc [NT];
  logic [NT*AW-1:0] exp_q [$];

  always #4 clk = ~clk;

  pulse_corr_channel #(.ACC_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .code_rst(code_rst), .smp_in(smp_in),
    .poly_a(poly_a), .poly_b(poly_b), .seed_a(seed_a), .seed_b(seed_b),
    .corr_out(corr_out), .corr_valid(corr_valid), .chip_out(chip_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // R6: independent model of the two-register code
  task automatic make_chips();
    int ra, rb, fa, fb;
    ra = int'(seed_a);
    rb = int'(seed_b);
    for (int j = 0; j < NC; j++) begin
      chips[j] = bit'((ra ^ rb) & 1);
      fa = 0;
      fb = 0;
      for (int b = 0; b < 5; b++) begin
        fa = fa ^ (((ra >> b) & 1) & ((int'(poly_a) >> b) & 1));
        fb = fb ^ (((rb >> b) & 1) & ((int'(poly_b) >> b) & 1));
      end
      ra = (ra >> 1) | (fa << 4);
      rb = (rb >> 1) | (fb << 4);
    end
  endtask

  // driver: one whole bit; mode 0 zero, 1 random, 2 drive up, 3 drive down, 4 constant
  task automatic run_bit(int mode);
    logic [NT*AW-1:0] e;
    make_chips();
    for (int k = 0; k < NT; k++) acc[k] = 0;
    for (int t = 0; t < NT*NC; t++) begin
      int lane [4];
      int s, j, p;
      j = t / NT;
      p = t % NT;
      s = 0;
      for (int i = 0; i < 4; i++) begin
        case (mode)
          0: lane[i] = 0;
          1: lane[i] = int'($urandom_range(15)) - 8;
          2: lane[i] = chips[j] ? -8 : 7;
          3: lane[i] = chips[j] ? 7 : -8;
          default: lane[i] = (i % 2 == 0) ? 5 : -2;
        endcase
        smp_in[i*4 +: 4] = 4'(lane[i]);
        s = s + lane[i];
      end
      acc[p] = clip(chips[j] ? acc[p] - s : acc[p] + s);
      #1;
      if (p == 0) check("R5/R6 chip_out", int'(chip_out), int'(chips[j]));
      @(negedge clk);
    end
    for (int k = 0; k < NT; k++) e[k*AW +: AW] = AW'(acc[k]);
    exp_q.push_back(e);
    sent_bits++;
  endtask

  task automatic restart(logic [4:0] sa, logic [4:0] sb, logic [4:0] pa, logic [4:0] pb);
    code_rst = 1'b1;
    seed_a = sa; seed_b = sb; poly_a = pa; poly_b = pb;
    smp_in = 16'h7777;
    @(negedge clk);
    code_rst = 1'b0;
  endtask

  // monitor: compare each strobe against the oldest expected item (R2, R3, R4, R7, R8)
  always @(negedge clk) begin
    if (rst_n && corr_valid) begin
      got_bits++;
      if (exp_q.size() == 0) begin
        check("R9 unexpected strobe", 1, 0);
      end else begin
        logic [NT*AW-1:0] e;
        e = exp_q.pop_front();
        for (int k = 0; k < NT; k++)
          check("R4/R7/R8 slot total", int'($signed(corr_out[k*AW +: AW])),
                int'($signed(e[k*AW +: AW])));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_a = 5'b00001; seed_b = 5'b10110;
    poly_a = 5'b00101; poly_b = 5'b01111;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 corr_valid", int'(corr_valid), 0);
    check("R1 corr_out", int'(corr_out == '0), 1);
    check("R1 chip_out", int'(chip_out), int'(seed_a[0] ^ seed_b[0]));
    rst_n = 1'b1;
    run_bit(0);                  // R2 zero input
    run_bit(1);                  // R2 R3 random
    run_bit(4);                  // R7 consecutive bit starts from zero
    restart(5'b10011, 5'b01010, 5'b01001, 5'b11011);   // R6 new code
    run_bit(1);
    run_bit(2);                  // R8 upper rail
    run_bit(3);                  // R8 lower rail
    // R9: abandon a bit midway, then restart
    for (int t = 0; t < 70; t++) begin
      smp_in = 16'h7777;
      @(negedge clk);
    end
    restart(5'b11100, 5'b00111, 5'b10010, 5'b11110);
    run_bit(4);
    run_bit(1);
    repeat (4) @(negedge clk);
    check("R7 strobe after each bit", got_bits, sent_bits);
    check("R9 no pending item", exp_q.size(), 0);
    check("R7 corr_valid idle", int'(corr_valid), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule